// File: doc/BRIEF.md
# Windowed Kicker Trigger Selector

This block produces the single trigger for a beam transfer kicker. It watches a synchronization-window gate and a once-per-revolution bucket-marker pulse train. After it is armed, it takes the first marker that arrives while the gate is open and starts a compensation delay, counted in system clock cycles. When the delay ends it drives one output pulse of programmable width. It then waits in a fired state until it is armed again. The gate, marker and machine-protection inputs are asynchronous. Each passes through a two-flop synchronizer, and its rising edge is detected.

The delay depends on the mode. In normal mode it is the kicker compensation alone, which covers the cable, electronics and kicker preparation latency. In emergency mode it is the kicker compensation plus a bunch-gap compensation. Emergency mode applies when the mode select is high. It also applies when a machine-protection request rises while the unit is armed or delaying, and in that case the delay is still measured from the selected marker. If the gate closes before any marker is seen, a missed-window flag is raised and no trigger is issued.

Top module: `kick_trigger_sel`

## Requirements
- R1: After reset, `trig_o` and `missed_o` are low and the unit is idle: markers cause no trigger until `arm_i` is seen high at a clock edge.
- R2: `gate_i`, `marker_i` and `mps_i` each pass through two synchronizing flops, and only their rising edges act. A marker counts as inside the window only if the gate is sampled high at the same edge at which the marker is first sampled high. A marker that first samples high at the same edge where the gate first samples low is outside the window.
- R3: Only the first marker rising edge inside the window is selected. Later markers and a marker held high do not produce another trigger.
- R4: In normal mode with kicker delay K, let edge 1 be the clock edge that first samples the selected marker high. `trig_o` goes high after edge max(K,1)+3.
- R5: With `emerg_mode_i` high, the delay is K+G, where G is `gap_dly_i`.
- R6: A rising edge on `mps_i` while the unit is armed or delaying switches the delay to K+G, still counted from the selected marker. A request seen while idle has no effect, and arming clears the emergency condition.
- R7: If the gate falls while the unit is armed and no marker has been selected, `missed_o` goes high and no trigger follows. The next accepted arm clears `missed_o`.
- R8: `trig_o` stays high for `pulse_w_i` cycles. A value of 0 selects the default width PW_DEFAULT (8).
- R9: Arming is accepted only when the unit is idle or fired, so an arm while delaying has no effect. Each accepted arm gives at most one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Synchronous arm strobe (software or timing event) |
| emerg_mode_i | input | 1 | Mode select, high for emergency delay |
| gate_i | input | 1 | Synchronization window gate, asynchronous |
| marker_i | input | 1 | Once-per-revolution bucket marker, asynchronous |
| mps_i | input | 1 | Machine-protection emergency request, asynchronous |
| kick_dly_i | input | DLY_W | Kicker compensation delay in cycles |
| gap_dly_i | input | DLY_W | Bunch-gap compensation delay in cycles |
| pulse_w_i | input | PW_W | Output pulse width in cycles, 0 for default |
| trig_o | output | 1 | Kicker trigger pulse |
| missed_o | output | 1 | Window closed with no marker |

## Verification
On every cycle, the assertions check the legal moves of the control state. A trigger may start only from the delaying state, and a missed flag may start only from the armed state. A marker inside the window always starts the delay, and a fired unit stays fired until it is armed again. A protection request while the unit is active always latches emergency.

The exact trigger timing under each delay choice, the pulse width and the default width cannot be shown by these per-cycle checks. Nor can the treatment of markers at the window edge or the clearing of the missed flag. The bench's scenarios show these by comparing against a reference model on every clock and by measuring the rise time and width directly.

// File: rtl/kick_trigger_sel.sv
`timescale 1ns/1ps
module kick_trigger_sel #(
  parameter int DLY_W      = 16,
  parameter int PW_W       = 8,
  parameter int PW_DEFAULT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             emerg_mode_i,
  input  logic             gate_i,
  input  logic             marker_i,
  input  logic             mps_i,
  input  logic [DLY_W-1:0] kick_dly_i,
  input  logic [DLY_W-1:0] gap_dly_i,
  input  logic [PW_W-1:0]  pulse_w_i,
  output logic             trig_o,
  output logic             missed_o
);
  localparam int CW = DLY_W + 1;
  localparam logic [PW_W-1:0] PW_DEF_V = PW_W'(PW_DEFAULT);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_DELAY, S_FIRED} st_t;

  st_t             st;
  logic [2:0]      gate_q, mark_q, mps_q;
  logic [CW-1:0]   cnt;
  logic [PW_W-1:0] pw_cnt;
  logic            emerg_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gate_q <= '0;
      mark_q <= '0;
      mps_q  <= '0;
    end else begin
      gate_q <= {gate_q[1:0], gate_i};
      mark_q <= {mark_q[1:0], marker_i};
      mps_q  <= {mps_q[1:0], mps_i};
    end

  wire gate_lvl  = gate_q[1];
  wire gate_fall = ~gate_q[1] & gate_q[2];
  wire mark_rise = mark_q[1] & ~mark_q[2];
  wire mps_rise  = mps_q[1] & ~mps_q[2];
  wire active    = (st == S_ARMED) || (st == S_DELAY);
  wire use_gap   = emerg_mode_i | emerg_lat | (mps_rise & active);

  wire [CW-1:0]   tgt     = {1'b0, kick_dly_i} + (use_gap ? {1'b0, gap_dly_i} : '0);
  wire [CW-1:0]   cnt_nx  = cnt + 1'b1;
  wire            fire    = (st == S_DELAY) && (cnt_nx >= tgt);
  wire [PW_W-1:0] pw_load = (pulse_w_i == '0) ? PW_DEF_V : pulse_w_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      emerg_lat <= 1'b0;
      missed_o  <= 1'b0;
      pw_cnt    <= '0;
    end else begin
      if (fire) pw_cnt <= pw_load;
      else if (pw_cnt != '0) pw_cnt <= pw_cnt - 1'b1;
      case (st)
        S_IDLE, S_FIRED:
          if (arm_i) begin
            st        <= S_ARMED;
            missed_o  <= 1'b0;
            emerg_lat <= 1'b0;
          end
        S_ARMED: begin
          if (mps_rise) emerg_lat <= 1'b1;
          if (mark_rise && gate_lvl) begin
            st  <= S_DELAY;
            cnt <= '0;
          end else if (gate_fall) begin
            st       <= S_IDLE;
            missed_o <= 1'b1;
          end
        end
        S_DELAY: begin
          if (mps_rise) emerg_lat <= 1'b1;
          if (fire) st <= S_FIRED;
          else cnt <= cnt_nx;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign trig_o = pw_cnt != '0;

  assert_trig_from_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(st) == S_DELAY);
  assert_missed_from_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(missed_o) |-> ($past(st) == S_ARMED) && (st == S_IDLE));
  assert_first_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && mark_rise && gate_lvl) |=> st == S_DELAY);
  assert_single_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DELAY) |=> (st == S_DELAY || st == S_FIRED));
  assert_fired_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIRED && !arm_i) |=> st == S_FIRED);
  assert_mps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mps_rise) |=> emerg_lat);
endmodule

// File: tb/kick_trigger_sel_tb.sv
`timescale 1ns/1ps
module kick_trigger_sel_tb_top;
  logic clk = 0, rst_n = 0, arm = 0, emode = 0, gate = 0, mark = 0, mps = 0;
  logic [15:0] kdly = 16'd20, gdly = 16'd15;
  logic [7:0]  pw = 8'd4;
  logic trig, missed;
  int nchk = 0, nfail = 0;
  string req = "R1";

  always #2 clk = ~clk;

  kick_trigger_sel dut_i (.clk(clk), .rst_n(rst_n), .arm_i(arm), .emerg_mode_i(emode),
    .gate_i(gate), .marker_i(mark), .mps_i(mps), .kick_dly_i(kdly), .gap_dly_i(gdly),
    .pulse_w_i(pw), .trig_o(trig), .missed_o(missed));

  // behavioural reference: state 0 idle, 1 armed, 2 delaying, 3 fired
  int m_st, m_cnt, m_pw, m_elat, m_miss;
  bit g[3], mk[3], p[3];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pw = 0; m_elat = 0; m_miss = 0;
      g = '{0,0,0}; mk = '{0,0,0}; p = '{0,0,0};
    end else begin
      bit gf, mr, pr, act;
      int t;
      gf = !g[1] && g[2]; mr = mk[1] && !mk[2]; pr = p[1] && !p[2];
      act = (m_st == 1 || m_st == 2);
      t = kdly + ((emode || m_elat || (pr && act)) ? gdly : 0);
      if (m_pw > 0) m_pw--;
      if (m_st == 0 || m_st == 3) begin
        if (arm) begin m_st = 1; m_miss = 0; m_elat = 0; end
      end else if (m_st == 1) begin
        if (pr) m_elat = 1;
        if (mr && g[1]) begin m_st = 2; m_cnt = 0; end
        else if (gf) begin m_st = 0; m_miss = 1; end
      end else begin
        if (pr) m_elat = 1;
        if (m_cnt + 1 >= t) begin m_st = 3; m_pw = (pw == 0) ? 8 : pw; end
        else m_cnt++;
      end
      g[2] = g[1]; g[1] = g[0]; g[0] = gate;
      mk[2] = mk[1]; mk[1] = mk[0]; mk[0] = mark;
      p[2] = p[1]; p[1] = p[0]; p[0] = mps;
    end
  end

  int rises = 0;
  bit trig_d = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      nchk++;
      if (trig !== (m_pw > 0) || missed !== m_miss[0]) begin
        nfail++;
        $display("FAIL %s: trig=%0b missed=%0b expected trig=%0b missed=%0b",
                 req, trig, missed, m_pw > 0, m_miss[0]);
      end
      if (trig && !trig_d) rises++;
    end
    trig_d = trig;
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic check(bit ok, string r, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask
  task automatic do_arm();
    arm = 1; tick(); arm = 0;
  endtask
  task automatic rise_after(int exp, string r);
    int n = 0;
    mark = 1;
    while (!trig && n < 500) begin tick(); n++; end
    check(n == exp, r, n, exp);
    mark = 0;
  endtask
  task automatic width(int exp, string r);
    int w = 0;
    while (trig && w < 300) begin w++; tick(); end
    check(w == exp, r, w, exp);
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    req = "R1";
    check(!trig && !missed, "R1", trig, 0);
    gate = 1; tick(2); mark = 1; tick(4); mark = 0; tick(30);
    check(rises == 0, "R1", rises, 0);
    gate = 0; tick(5);

    req = "R4"; rises = 0;
    do_arm(); gate = 1; tick(4);
    rise_after(23, "R4");
    req = "R8"; width(4, "R8");
    gate = 0; tick(10);

    req = "R3"; rises = 0; kdly = 16'd10;
    do_arm(); gate = 1; tick(4);
    mark = 1; tick(3); mark = 0; tick(3); mark = 1; tick(3); mark = 0;
    tick(40); mark = 1; tick(30); mark = 0; gate = 0; tick(10);
    check(rises == 1, "R3", rises, 1);

    req = "R5"; rises = 0; emode = 1; kdly = 16'd20; pw = 8'd0;
    do_arm(); gate = 1; tick(4);
    rise_after(38, "R5");
    req = "R8"; width(8, "R8");
    gate = 0; emode = 0; pw = 8'd3; tick(10);

    req = "R6"; rises = 0; kdly = 16'd30; gdly = 16'd12;
    mps = 1; tick(4); mps = 0; tick(4);
    do_arm(); gate = 1; tick(4);
    fork
      rise_after(45, "R6");
      begin tick(10); mps = 1; tick(3); mps = 0; end
    join
    req = "R8"; width(3, "R8");
    gate = 0; tick(10);
    req = "R6"; mps = 1; tick(3); mps = 0; tick(3);
    do_arm(); gate = 1; tick(4);
    rise_after(33, "R6");
    gate = 0; tick(10);

    req = "R7"; rises = 0;
    do_arm(); gate = 1; tick(20); gate = 0; tick(5);
    check(missed == 1, "R7", missed, 1);
    mark = 1; tick(3); mark = 0; tick(40);
    check(rises == 0, "R7", rises, 0);
    do_arm(); tick(2);
    check(missed == 0, "R7", missed, 0);
    gate = 1; tick(5); gate = 0; tick(5);

    req = "R2"; rises = 0;
    do_arm(); gate = 1; tick(10);
    gate = 0; mark = 1; tick(4); mark = 0; tick(40);
    check(rises == 0 && missed == 1, "R2", rises, 0);

    req = "R9"; rises = 0; kdly = 16'd25;
    do_arm(); gate = 1; tick(4);
    mark = 1; tick(8); mark = 0;
    do_arm(); tick(3);
    mark = 1; tick(3); mark = 0; tick(60);
    mark = 1; tick(3); mark = 0; tick(20);
    check(rises == 1, "R9", rises, 1);
    gate = 0; tick(5);
    req = "R4"; kdly = 16'd0; rises = 0;
    do_arm(); gate = 1; tick(4);
    rise_after(4, "R4");
    gate = 0; tick(10);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule